// File: doc/BRIEF.md
# Debug Instruction Transfer Controller

This block sits behind a boundary-scan style test access port and lets an external debugger drive a halted processor core. The port's state machine is external. It supplies single-cycle strobes for the capture, shift and update phases of a data-register scan and for each pass through the idle state, plus the current 4-bit instruction-register opcode and the serial input bit. The block owns the data registers behind the port. These are a chain-select register, a debug status/control word, a 32-bit instruction transfer register and a data transfer register.

A debugger first writes a chain number into the chain-select register. It then reads the selected chain under the read opcode or writes it under the write opcode. Once an instruction word has been written into the instruction transfer register, each pass through the idle state hands that word to the core as a one-cycle issue strobe, provided a set of conditions holds. The word stays in place, so the same instruction can be issued again and again without a new scan. The core reports completion, faults and data through handshake inputs. Reading the status word clears its sticky fault flags.

Top module: `dbg_xfer_ctrl`

## Requirements
- R1: After reset, `issue` is 0, `instr` is 0 and `tdo` is 0. The status word reads ready=1 (bit 1), execute-enable=0 (bit 13) and all sticky flags 0.
- R2: Opcode 4'h2 selects the 5-bit chain-select register. Capture loads its current value, and update stores the shifted value. Every scan shifts LSB first toward `tdo`.
- R3: With chain 1 selected, opcode 4'hC (read) captures the status word and opcode 4'h0 (write) stores only bit 13 (execute-enable) on update. The status word holds halted in bit 0, ready in bit 1, sticky precise abort in bit 6, sticky imprecise abort in bit 7, sticky undefined in bit 8 and execute-enable in bit 13. All other bits read 0.
- R4: With chain 4 selected, a write-opcode update loads the 32-bit instruction transfer register, whose value drives `instr`.
- R5: A `rti` strobe raises `issue` for exactly one cycle, in the cycle after the strobe. This happens only when the opcode is 4'hC or 4'h0 and the selected chain is 4 or 5. No other opcode or chain issues.
- R6: No issue takes place while execute-enable is 0, or while `core_halted` is 0.
- R7: Ready falls at issue and rises on `core_done`. While ready is 0, `rti` issues nothing and instruction-register updates are ignored.
- R8: A later `rti` reissues the same `instr` without a new scan.
- R9: A `core_dabort_p` pulse sets the sticky precise abort flag. While that flag is set, `rti` issues nothing and instruction-register updates are ignored.
- R10: A read-opcode capture of chain 1 returns the sticky flags and then clears all three, unless a fault input is high in the same cycle.
- R11: A `core_dtr_we` pulse loads `core_dtr` into the data transfer register. A read-opcode scan of chain 5 returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_dr | input | 1 | Capture-phase strobe |
| shf_dr | input | 1 | Shift-phase strobe |
| upd_dr | input | 1 | Update-phase strobe |
| rti | input | 1 | Pass-through-idle strobe |
| ir_op | input | 4 | Current instruction-register opcode |
| tdi | input | 1 | Serial scan input |
| core_halted | input | 1 | Core is in debug state |
| core_done | input | 1 | Core finished the issued instruction |
| core_dabort_p | input | 1 | Precise data abort pulse |
| core_dabort_i | input | 1 | Imprecise data abort pulse |
| core_undef | input | 1 | Undefined instruction pulse |
| core_dtr_we | input | 1 | Core writes the data transfer register |
| core_dtr | input | 32 | Data written by the core |
| tdo | output | 1 | Serial scan output (bit 0 of shift register) |
| issue | output | 1 | One-cycle instruction issue strobe |
| instr | output | 32 | Instruction word for the core |

## Verification
Every register update lands on the clock edge that samples its strobe. A capture therefore shows its first bit on `tdo` one cycle after `cap_dr`, and each later bit appears one cycle after the previous shift. `issue` goes high one cycle after `rti`, and ready falls at that same edge. Updates are visible on `instr` and in the status word the cycle after `upd_dr`. The bench drives every strobe on the falling edge and samples on the next falling edge, one register stage after the stimulus. It reads the status word back through a scan so that ignored writes and cleared flags are observed at the port.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;

    localparam int IR_W = 4;

    // Opcodes
    localparam logic [IR_W-1:0] OP_WRITE = 4'h0;
    localparam logic [IR_W-1:0] OP_SEL   = 4'h2;
    localparam logic [IR_W-1:0] OP_READ  = 4'hC;

    // Chain numbers
    localparam int CH_STAT = 1;
    localparam int CH_INSN = 4;
    localparam int CH_DATA = 5;

    // Status word bit positions
    localparam int B_HALT  = 0;
    localparam int B_READY = 1;
    localparam int B_SPA   = 6;
    localparam int B_SIA   = 7;
    localparam int B_SUND  = 8;
    localparam int B_EXEC  = 13;

    typedef enum logic [2:0] {
        DR_BYP, DR_SEL, DR_STAT, DR_INSN, DR_DATA
    } dr_kind_t;

    typedef struct packed {
        logic spa;
        logic sia;
        logic sund;
    } sticky_t;

    function automatic logic is_chain_op(input logic [IR_W-1:0] op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

    function automatic dr_kind_t decode_kind(input logic [IR_W-1:0] op, input int sel);
        if (op == OP_SEL)
            return DR_SEL;
        if (is_chain_op(op)) begin
            case (sel)
                CH_STAT: return DR_STAT;
                CH_INSN: return DR_INSN;
                CH_DATA: return DR_DATA;
                default: return DR_BYP;
            endcase
        end
        return DR_BYP;
    endfunction

    function automatic logic issue_path_ok(input logic [IR_W-1:0] op, input int sel);
        return is_chain_op(op) && (sel == CH_INSN || sel == CH_DATA);
    endfunction

endpackage

// File: rtl/dx_shift.sv
module dx_shift #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              shf,
    input  logic              tdi,
    input  logic [IDX_W-1:0]  msb_idx,
    input  logic [DATA_W-1:0] cap_val,
    output logic [DATA_W-1:0] sh_q,
    output logic              tdo
);
    logic [DATA_W-1:0] sh_nx;

    always_comb begin
        sh_nx = sh_q >> 1;
        sh_nx[msb_idx] = tdi;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (cap)
            sh_q <= cap_val;
        else if (shf)
            sh_q <= sh_nx;
    end

    assign tdo = sh_q[0];
endmodule

// File: rtl/dx_status.sv
module dx_status
    import dbg_xfer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_wr,
    input  logic              exec_d,
    input  logic              rd_clr,
    input  logic              ab_p,
    input  logic              ab_i,
    input  logic              undef,
    input  logic              dtr_we,
    input  logic [DATA_W-1:0] dtr_d,
    output logic              exec_en,
    output sticky_t           stk,
    output logic [DATA_W-1:0] dtr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            exec_en <= 1'b0;
            stk     <= '0;
            dtr_q   <= '0;
        end else begin
            if (exec_wr)
                exec_en <= exec_d;
            // a new fault wins over the read-clear
            stk.spa  <= ab_p  | (stk.spa  & ~rd_clr);
            stk.sia  <= ab_i  | (stk.sia  & ~rd_clr);
            stk.sund <= undef | (stk.sund & ~rd_clr);
            if (dtr_we)
                dtr_q <= dtr_d;
        end
    end
endmodule

// File: rtl/dx_issue.sv
module dx_issue #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rti,
    input  logic              path_ok,
    input  logic              exec_en,
    input  logic              halted,
    input  logic              spa,
    input  logic              done,
    input  logic              itr_we,
    input  logic [DATA_W-1:0] itr_d,
    output logic              issue,
    output logic              ready,
    output logic [DATA_W-1:0] itr_q
);
    logic fire;
    logic accept;

    assign fire   = rti && path_ok && exec_en && halted && ready && !spa;
    assign accept = itr_we && ready && !spa;

    always_ff @(posedge clk) begin
        if (rst) begin
            issue <= 1'b0;
            ready <= 1'b1;
            itr_q <= '0;
        end else begin
            issue <= fire;
            if (fire)
                ready <= 1'b0;
            else if (done)
                ready <= 1'b1;
            if (accept)
                itr_q <= itr_d;
        end
    end
endmodule

// File: rtl/dbg_xfer_ctrl.sv
module dbg_xfer_ctrl
    import dbg_xfer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_dr,
    input  logic              shf_dr,
    input  logic              upd_dr,
    input  logic              rti,
    input  logic [IR_W-1:0]   ir_op,
    input  logic              tdi,
    input  logic              core_halted,
    input  logic              core_done,
    input  logic              core_dabort_p,
    input  logic              core_dabort_i,
    input  logic              core_undef,
    input  logic              core_dtr_we,
    input  logic [DATA_W-1:0] core_dtr,
    output logic              tdo,
    output logic              issue,
    output logic [DATA_W-1:0] instr
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [SEL_W-1:0]  sel_q;
    dr_kind_t          kind;
    logic [IDX_W-1:0]  msb_idx;
    logic [DATA_W-1:0] cap_val;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] stat_view;
    logic [DATA_W-1:0] dtr_q;
    logic              exec_en;
    sticky_t           stk;
    logic              ready_w;
    logic              spa_w;
    logic              rd_clr;
    logic              exec_wr;
    logic              itr_we;
    logic              path_ok;

    assign kind    = decode_kind(ir_op, int'(sel_q));
    assign path_ok = issue_path_ok(ir_op, int'(sel_q));
    assign rd_clr  = cap_dr && kind == DR_STAT && ir_op == OP_READ;
    assign exec_wr = upd_dr && kind == DR_STAT && ir_op == OP_WRITE;
    assign itr_we  = upd_dr && kind == DR_INSN && ir_op == OP_WRITE;
    assign spa_w   = stk.spa;

    always_comb begin
        stat_view          = '0;
        stat_view[B_HALT]  = core_halted;
        stat_view[B_READY] = ready_w;
        stat_view[B_SPA]   = stk.spa;
        stat_view[B_SIA]   = stk.sia;
        stat_view[B_SUND]  = stk.sund;
        stat_view[B_EXEC]  = exec_en;
    end

    always_comb begin
        case (kind)
            DR_SEL: begin
                msb_idx = IDX_W'(SEL_W - 1);
                cap_val = DATA_W'(sel_q);
            end
            DR_STAT: begin
                msb_idx = IDX_W'(DATA_W - 1);
                cap_val = stat_view;
            end
            DR_INSN: begin
                msb_idx = IDX_W'(DATA_W - 1);
                cap_val = instr;
            end
            DR_DATA: begin
                msb_idx = IDX_W'(DATA_W - 1);
                cap_val = dtr_q;
            end
            default: begin
                msb_idx = '0;
                cap_val = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (upd_dr && kind == DR_SEL)
            sel_q <= sh_q[SEL_W-1:0];
    end

    dx_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
        .clk(clk), .rst(rst), .cap(cap_dr), .shf(shf_dr), .tdi(tdi),
        .msb_idx(msb_idx), .cap_val(cap_val), .sh_q(sh_q), .tdo(tdo)
    );

    dx_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst(rst), .exec_wr(exec_wr), .exec_d(sh_q[B_EXEC]),
        .rd_clr(rd_clr), .ab_p(core_dabort_p), .ab_i(core_dabort_i),
        .undef(core_undef), .dtr_we(core_dtr_we), .dtr_d(core_dtr),
        .exec_en(exec_en), .stk(stk), .dtr_q(dtr_q)
    );

    dx_issue #(.DATA_W(DATA_W)) u_issue (
        .clk(clk), .rst(rst), .rti(rti), .path_ok(path_ok),
        .exec_en(exec_en), .halted(core_halted), .spa(spa_w),
        .done(core_done), .itr_we(itr_we), .itr_d(sh_q),
        .issue(issue), .ready(ready_w), .itr_q(instr)
    );
endmodule

// File: rtl/dx_chk.sv
module dx_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rti,
    input logic              issue,
    input logic [DATA_W-1:0] instr,
    input logic              ready,
    input logic              exec_en,
    input logic              halted,
    input logic              spa,
    input logic              rd_clr,
    input logic              ab_p
);
    a_r5_issue_follows_rti: assert property (@(posedge clk) disable iff (rst)
        issue |-> $past(rti));

    a_r5_issue_one_cycle: assert property (@(posedge clk) disable iff (rst)
        issue |=> !issue);

    a_r6_issue_needs_enable: assert property (@(posedge clk) disable iff (rst)
        issue |-> $past(exec_en) && $past(halted));

    a_r7_ready_low_at_issue: assert property (@(posedge clk) disable iff (rst)
        issue |-> !ready);

    a_r7_issue_needs_ready: assert property (@(posedge clk) disable iff (rst)
        issue |-> $past(ready));

    a_r9_issue_blocked_by_abort: assert property (@(posedge clk) disable iff (rst)
        issue |-> !$past(spa));

    a_r9_insn_frozen: assert property (@(posedge clk) disable iff (rst)
        (!$past(ready) || $past(spa)) |-> $stable(instr));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_clr) && !$past(ab_p)) |-> !spa);
endmodule

bind dbg_xfer_ctrl dx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .rti(rti), .issue(issue), .instr(instr),
    .ready(ready_w), .exec_en(exec_en), .halted(core_halted),
    .spa(spa_w), .rd_clr(rd_clr), .ab_p(core_dabort_p)
);

// File: tb/dbg_xfer_ctrl_tb.sv
module dbg_xfer_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] OP_WR  = 4'h0;
    localparam logic [3:0] OP_SL  = 4'h2;
    localparam logic [3:0] OP_RD  = 4'hC;
    localparam logic [3:0] OP_OTH = 4'h7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cap_dr = 0, shf_dr = 0, upd_dr = 0, rti = 0, tdi = 0;
    logic [3:0] ir_op = 4'h0;
    logic core_halted = 0, core_done = 0, core_dabort_p = 0;
    logic core_dabort_i = 0, core_undef = 0, core_dtr_we = 0;
    logic [31:0] core_dtr = '0;
    logic tdo, issue;
    logic [31:0] instr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_xfer_ctrl u_dut (
        .clk(clk), .rst(rst), .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
        .rti(rti), .ir_op(ir_op), .tdi(tdi), .core_halted(core_halted),
        .core_done(core_done), .core_dabort_p(core_dabort_p),
        .core_dabort_i(core_dabort_i), .core_undef(core_undef),
        .core_dtr_we(core_dtr_we), .core_dtr(core_dtr),
        .tdo(tdo), .issue(issue), .instr(instr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dr_scan(input logic [31:0] din, input int len, output logic [31:0] dout);
        dout = '0;
        @(negedge clk) cap_dr = 1;
        @(negedge clk) cap_dr = 0;
        for (int i = 0; i < len; i++) begin
            shf_dr = 1;
            tdi = din[i];
            dout[i] = tdo;
            @(negedge clk);
        end
        shf_dr = 0;
        upd_dr = 1;
        @(negedge clk) upd_dr = 0;
    endtask

    task automatic select_chain(input int n, output logic [31:0] prev);
        ir_op = OP_SL;
        dr_scan(32'(n), 5, prev);
    endtask

    task automatic read_stat(output logic [31:0] v);
        logic [31:0] d;
        select_chain(1, d);
        ir_op = OP_RD;
        dr_scan('0, 32, v);
    endtask

    task automatic write_stat(input logic [31:0] v);
        logic [31:0] d;
        select_chain(1, d);
        ir_op = OP_WR;
        dr_scan(v, 32, d);
    endtask

    task automatic load_insn(input logic [31:0] v);
        logic [31:0] d;
        select_chain(4, d);
        ir_op = OP_WR;
        dr_scan(v, 32, d);
    endtask

    task automatic pass_idle(output logic got, output logic after);
        @(negedge clk) rti = 1;
        @(negedge clk) rti = 0;
        got = issue;
        @(negedge clk) after = issue;
    endtask

    task automatic pulse_done();
        @(negedge clk) core_done = 1;
        @(negedge clk) core_done = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 issue", 32'(issue), 0);
        check("R1 instr", instr, 0);
        check("R1 tdo", 32'(tdo), 0);
        read_stat(v);
        check("R1 status", v, 32'h0000_0002);
    endtask

    task automatic t_select();
        logic [31:0] p;
        select_chain(5, p);
        select_chain(1, p);
        check("R2 sel readback", p, 32'd5);
        select_chain(1, p);
        check("R2 sel readback 1", p, 32'd1);
    endtask

    task automatic t_stat_write();
        logic [31:0] v;
        core_halted = 1;
        write_stat(32'hFFFF_FFFF);
        read_stat(v);
        check("R3 only bit13 stored", v, 32'h0000_2003);
    endtask

    task automatic t_insn_load();
        load_insn(32'hE1A0_0000);
        check("R4 instr loaded", instr, 32'hE1A0_0000);
    endtask

    task automatic t_issue();
        logic g, a;
        logic [31:0] d;
        ir_op = OP_WR;
        pass_idle(g, a);
        check("R5 issue on idle", 32'(g), 1);
        check("R5 one-cycle pulse", 32'(a), 0);
        pass_idle(g, a);
        check("R7 no issue while busy", 32'(g), 0);
        load_insn(32'h1234_5678);
        check("R7 update ignored while busy", instr, 32'hE1A0_0000);
        pulse_done();
        ir_op = OP_WR;
        pass_idle(g, a);
        check("R8 reissue", 32'(g), 1);
        check("R8 same instr", instr, 32'hE1A0_0000);
        pulse_done();
        select_chain(5, d);
        ir_op = OP_RD;
        pass_idle(g, a);
        check("R5 chain 5 read op issues", 32'(g), 1);
        pulse_done();
        select_chain(1, d);
        ir_op = OP_WR;
        pass_idle(g, a);
        check("R5 chain 1 no issue", 32'(g), 0);
        select_chain(4, d);
        ir_op = OP_OTH;
        pass_idle(g, a);
        check("R5 other opcode no issue", 32'(g), 0);
        ir_op = OP_SL;
        pass_idle(g, a);
        check("R5 select opcode no issue", 32'(g), 0);
    endtask

    task automatic t_enable();
        logic g, a;
        logic [31:0] d;
        write_stat(32'h0);
        select_chain(4, d);
        ir_op = OP_WR;
        pass_idle(g, a);
        check("R6 disabled no issue", 32'(g), 0);
        write_stat(32'h0000_2000);
        core_halted = 0;
        select_chain(4, d);
        ir_op = OP_WR;
        pass_idle(g, a);
        check("R6 not halted no issue", 32'(g), 0);
        core_halted = 1;
        pass_idle(g, a);
        check("R6 halted and enabled issues", 32'(g), 1);
        pulse_done();
    endtask

    task automatic t_abort();
        logic g, a;
        logic [31:0] v;
        @(negedge clk) core_dabort_p = 1;
        @(negedge clk) core_dabort_p = 0;
        ir_op = OP_WR;
        pass_idle(g, a);
        check("R9 abort blocks issue", 32'(g), 0);
        load_insn(32'hDEAD_BEEF);
        check("R9 abort blocks update", instr, 32'hE1A0_0000);
        read_stat(v);
        check("R9 sticky precise shown", v, 32'h0000_2043);
        read_stat(v);
        check("R10 cleared after read", v, 32'h0000_2003);
        @(negedge clk) begin core_dabort_i = 1; core_undef = 1; end
        @(negedge clk) begin core_dabort_i = 0; core_undef = 0; end
        read_stat(v);
        check("R10 imprecise and undef shown", v, 32'h0000_2183);
        read_stat(v);
        check("R10 all cleared", v, 32'h0000_2003);
        load_insn(32'hDEAD_BEEF);
        check("R9 update after clear", instr, 32'hDEAD_BEEF);
        ir_op = OP_WR;
        pass_idle(g, a);
        check("R9 issue after clear", 32'(g), 1);
        pulse_done();
    endtask

    task automatic t_data();
        logic [31:0] v, d;
        @(negedge clk) begin core_dtr_we = 1; core_dtr = 32'hCAFE_1234; end
        @(negedge clk) core_dtr_we = 0;
        select_chain(5, d);
        ir_op = OP_RD;
        dr_scan('0, 32, v);
        check("R11 data readout", v, 32'hCAFE_1234);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_select();
        t_stat_write();
        t_insn_load();
        t_issue();
        t_enable();
        t_abort();
        t_data();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule